// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 18-bit buses, A and B, and carries data across without inverting it. Each crossing direction (A to B and B to A) has its own latch enable, capture clock and output enable. A direction is transparent while its latch enable is high. It holds its stored word while the latch enable is low and the capture clock is steady. It captures a new word when the capture clock falls while the latch enable is low. The A-to-B enable is active high and the B-to-A enable is active low. Three-state outputs are presented as a data word plus a drive flag, so the pad ring or a bus wrapper can build the actual tristate. When both directions drive at once, a contention flag is raised.

Everything runs on one system clock. The latch enables and capture clocks are treated as sampled control inputs: a capture-clock fall is seen when the clock is sampled high on one system-clock edge and low on the next. Each direction has exactly one storage register. While the latch enable is high, that register reloads the input on every system-clock edge. The live input feeds the output combinationally during transparency. The reset is asynchronous and active low. Its release passes through a two-stage synchronizer before the storage registers leave reset.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_out` equals `a_in` bit for bit in the same cycle, with no inversion.
- R2: While `le_ab` is low and `cp_ab` does not fall, `b_out` keeps the stored word even if `a_in` changes.
- R3: When `le_ab` is sampled low after being sampled high, the held word is the `a_in` value sampled at the last system-clock edge at which `le_ab` was high.
- R4: With `le_ab` low, `cp_ab` sampled high at one edge and low at the next loads `a_in`, sampled at that second edge, into storage. The word appears on `b_out` right after that edge.
- R5: A rising `cp_ab` (sampled low, then high) with `le_ab` low does not change storage.
- R6: `b_oe` is 1 exactly when `oe_ab` is 1 (active-high enable).
- R7: `a_oe` is 1 exactly when `oe_ba_n` is 0 (active-low enable).
- R8: `contention` is 1 exactly when `b_oe` and `a_oe` are both 1.
- R9: `rst_n` low clears both stored words to zero at once. Storage ignores all capture activity until two system-clock edges after `rst_n` rises. A capture clock that is already low at release does not capture.
- R10: The B-to-A path (`b_in`, `le_ba`, `cp_ba`, `a_out`) obeys R1 to R5 independently of the A-to-B path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word received from bus A |
| b_in | input | 18 | Word received from bus B |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| cp_ab | input | 1 | A-to-B capture clock, falling edge captures |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| cp_ba | input | 1 | B-to-A capture clock, falling edge captures |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word to drive onto bus B |
| b_oe | output | 1 | Drive flag for bus B |
| a_out | output | 18 | Word to drive onto bus A |
| a_oe | output | 1 | Drive flag for bus A |
| contention | output | 1 | Both directions are driving |

## Verification
Transparency and all three enable flags are combinational, so they are due in the same cycle as the stimulus. A capture or a latch-closing takes effect at the first system-clock edge that sees the new control level, and the stored word is visible just after that edge. A reset release takes effect two edges after `rst_n` rises. The bench drives every input on the falling system-clock edge and compares all outputs 2 ns later against a behavioural model. The model updates its state on each rising edge, so each result is checked in exactly the cycle it is due. The bound checker measures the same latencies with `$past` windows. It stays quiet until three edges after the synchronized release, so that the capture-clock history it looks at is valid.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Where a direction's output word comes from in the current cycle
  typedef enum logic {
    SRC_STORE = 1'b0,
    SRC_LIVE  = 1'b1
  } path_src_e;

  // Turn a raw enable pin into an active-high drive flag
  function automatic logic oe_decode(input logic raw, input bit active_low);
    return active_low ? ~raw : raw;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);

  logic sig_q;
  logic sig_d;

  always_comb begin
    sig_d = sig;
  end

  // Reset low: a signal already low at release is not a fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_d;
  end

  assign fall = sig_q & ~sig;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W             = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         cp,
  input  logic         oe_raw,
  output logic [W-1:0] dout,
  output logic         oe
);

  logic         cp_fall;
  logic         load_en;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  path_src_e    src;

  xcvr_fall_det u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (cp),
    .fall (cp_fall)
  );

  // Clock enable: reload while transparent, or on a capture-clock fall
  assign load_en = le | cp_fall;

  always_comb begin
    store_d = store_q;
    if (load_en) store_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  always_comb begin
    src  = le ? SRC_LIVE : SRC_STORE;
    dout = (src == SRC_LIVE) ? din : store_q;
  end

  assign oe = oe_decode(oe_raw, OE_ACTIVE_LOW);

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         cp_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         cp_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic         contention
);

  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic           rst_sync_n;
  logic [W-1:0]   din  [NDIR];
  logic [W-1:0]   dout [NDIR];
  logic [NDIR-1:0] le_v, cp_v, oe_raw_v, oe_v;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign din[0] = a_in;
  assign din[1] = b_in;
  assign le_v     = {le_ba, le_ab};
  assign cp_v     = {cp_ba, cp_ab};
  assign oe_raw_v = {oe_ba_n, oe_ab};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_lane #(
      .W            (W),
      .OE_ACTIVE_LOW(d == 1)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (din[d]),
      .le    (le_v[d]),
      .cp    (cp_v[d]),
      .oe_raw(oe_raw_v[d]),
      .dout  (dout[d]),
      .oe    (oe_v[d])
    );
  end

  assign b_out      = dout[0];
  assign b_oe       = oe_v[0];
  assign a_out      = dout[1];
  assign a_oe       = oe_v[1];
  assign contention = &oe_v;

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         le_ab,
  input logic         cp_ab,
  input logic         oe_ab,
  input logic         le_ba,
  input logic         cp_ba,
  input logic         oe_ba_n,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_out,
  input logic         contention
);

  // Age since synchronized release; history valid once saturated
  logic [1:0] age_q;
  logic       hist_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign hist_ok = (age_q == 2'd3);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_ok && !le_ab && $past(!le_ab) && ($past(cp_ab) == $past(cp_ab, 2)))
      |-> $stable(b_out));

  p_close_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_ok && !le_ab && $past(le_ab)) |-> (b_out == $past(a_in)));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_ok && !le_ab && $past(!le_ab) && $past(cp_ab, 2) && !$past(cp_ab))
      |-> (b_out == $past(a_in)));

  p_rise_ignored_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_ok && !le_ab && $past(!le_ab) && !$past(cp_ab, 2) && $past(cp_ab))
      |-> $stable(b_out));

  p_contention_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    contention == (oe_ab && !oe_ba_n));

  p_ba_capture_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_ok && !le_ba && $past(!le_ba) && $past(cp_ba, 2) && !$past(cp_ba))
      |-> (a_out == $past(b_in)));

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .a_in      (a_in),
  .b_in      (b_in),
  .le_ab     (le_ab),
  .cp_ab     (cp_ab),
  .oe_ab     (oe_ab),
  .le_ba     (le_ba),
  .cp_ba     (cp_ba),
  .oe_ba_n   (oe_ba_n),
  .b_out     (b_out),
  .a_out     (a_out),
  .contention(contention)
);

// File: tb/dual_path_xcvr_tb.sv
`timescale 1ns/1ps
module dual_path_xcvr_tb;

  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;
  logic [W-1:0] b_out, a_out;
  logic b_oe, a_oe, contention;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;  // 125 MHz

  dual_path_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .le_ab(le_ab), .cp_ab(cp_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .cp_ba(cp_ba), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .contention(contention)
  );

  // Behavioural reference: stored words, previous capture-clock samples,
  // and a release counter for the reset synchronizer.
  logic [W-1:0] m_ab, m_ba;
  bit m_cpq_ab, m_cpq_ba;
  int m_age;

  always @(negedge rst_n) begin
    m_ab = '0; m_ba = '0; m_cpq_ab = 0; m_cpq_ba = 0; m_age = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; m_cpq_ab = 0; m_cpq_ba = 0; m_age = 0;
    end else begin
      if (m_age >= 2) begin
        if (le_ab || (m_cpq_ab && !cp_ab)) m_ab = a_in;
        if (le_ba || (m_cpq_ba && !cp_ba)) m_ba = b_in;
        m_cpq_ab = cp_ab;
        m_cpq_ba = cp_ba;
      end
      if (m_age < 2) m_age++;
    end
  end

  task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] eb, ea;
    bit eboe, eaoe;
    eb   = le_ab ? a_in : m_ab;
    ea   = le_ba ? b_in : m_ba;
    eboe = oe_ab;
    eaoe = !oe_ba_n;
    cmp("b_out", b_out, eb);
    cmp("a_out", a_out, ea);
    cmp("b_oe", W'(b_oe), W'(eboe));
    cmp("a_oe", W'(a_oe), W'(eaoe));
    cmp("contention", W'(contention), W'(eboe & eaoe));
  endtask

  // Drive on the falling edge, compare 2 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #2 check_all();
  endtask

  task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic lab, input logic cab,
                     input logic lba, input logic cba);
    step();
    a_in = a; b_in = b; le_ab = lab; cp_ab = cab; le_ba = lba; cp_ba = cba;
    settle();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; a_in = '0; b_in = '0;
    le_ab = 0; cp_ab = 0; oe_ab = 0; le_ba = 0; cp_ba = 0; oe_ba_n = 1;
    // R9: reset state, capture activity during reset ignored
    cur_req = "R9";
    #1 check_all();
    cyc(18'h12345, 18'h2ABCD, 0, 1, 0, 1);
    cyc(18'h12345, 18'h2ABCD, 0, 0, 0, 0);
    cyc(18'h00F0F, 18'h3F0F0, 0, 0, 0, 0);
    step(); rst_n = 1; settle();
    // R9: capture clock low at release does not capture
    cyc(18'h11111, 18'h22222, 0, 0, 0, 0);
    cyc(18'h11111, 18'h22222, 0, 0, 0, 0);
    cyc(18'h11111, 18'h22222, 0, 0, 0, 0);

    // R1: transparency, several patterns
    cur_req = "R1";
    cyc(18'h3FFFF, 18'h0, 1, 0, 0, 0);
    cyc(18'h15555, 18'h0, 1, 0, 0, 0);
    cyc(18'h2AAAA, 18'h0, 1, 0, 0, 0);
    cyc(18'h00001, 18'h0, 1, 0, 0, 0);
    cyc(18'h20000, 18'h0, 1, 0, 0, 0);
    // R3: closing the latch keeps the last sampled transparent word
    cur_req = "R3";
    cyc(18'h0BEEF, 18'h0, 0, 0, 0, 0);
    // R2: hold while inputs change, capture clock steady
    cur_req = "R2";
    for (int i = 0; i < 4; i++) cyc(W'(i * 18'h0913), 18'h0, 0, 0, 0, 0);
    // R4: falling capture clock loads input
    cur_req = "R4";
    cyc(18'h13579, 18'h0, 0, 1, 0, 0);
    cyc(18'h2468A, 18'h0, 0, 0, 0, 0);
    cyc(18'h00000, 18'h0, 0, 0, 0, 0);
    cyc(18'h3C3C3, 18'h0, 0, 1, 0, 0);
    cyc(18'h0A5A5, 18'h0, 0, 0, 0, 0);
    // R5: rising capture clock is ignored
    cur_req = "R5";
    cyc(18'h1FFFF, 18'h0, 0, 1, 0, 0);
    cyc(18'h1EEEE, 18'h0, 0, 1, 0, 0);

    // R10: B-to-A path, same sequence
    cur_req = "R10";
    cyc(18'h0, 18'h3FFFF, 0, 1, 1, 0);
    cyc(18'h0, 18'h12121, 1, 1, 1, 0);
    cyc(18'h0, 18'h34343, 0, 1, 0, 0);
    cyc(18'h0, 18'h05050, 0, 1, 0, 1);
    cyc(18'h0, 18'h26262, 0, 1, 0, 0);
    cyc(18'h0, 18'h17171, 0, 1, 0, 1);

    // R6, R7, R8: enables and contention
    cur_req = "R6";
    step(); oe_ab = 1; settle();
    cur_req = "R7";
    step(); oe_ab = 0; oe_ba_n = 0; settle();
    cur_req = "R8";
    step(); oe_ab = 1; oe_ba_n = 0; settle();
    step(); oe_ab = 1; oe_ba_n = 1; settle();

    // R10/R8: random mix of both directions
    cur_req = "R10";
    for (int i = 0; i < 300; i++) begin
      step();
      a_in = W'($urandom); b_in = W'($urandom);
      le_ab = ($urandom % 4) == 0; le_ba = ($urandom % 4) == 0;
      cp_ab = $urandom; cp_ba = $urandom;
      oe_ab = $urandom; oe_ba_n = $urandom;
      settle();
    end

    // R9: asynchronous clear in mid-cycle
    cur_req = "R9";
    cyc(18'h2DEAD, 18'h1BEEF, 1, 0, 1, 0);
    cyc(18'h00000, 18'h00000, 0, 0, 0, 0);
    #1 rst_n = 0;
    #1 check_all();
    step(); rst_n = 1; settle();
    cyc(18'h3AAAA, 18'h05555, 0, 1, 0, 1);
    cyc(18'h3AAAA, 18'h05555, 0, 0, 0, 0);
    cyc(18'h3AAAA, 18'h05555, 0, 1, 0, 1);
    cyc(18'h1CCCC, 18'h03333, 0, 0, 0, 0);
    cyc(18'h1CCCC, 18'h03333, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule